// File: doc/BRIEF.md
# Two-Channel Prescaled Interval Timer

This block is a register-mapped interval timer with two independent 16-bit channels. Each channel counts upward from zero at a rate set by a power-of-two prescaler. When the count reaches the programmed limit, the channel flags an event, returns to zero and either keeps running (periodic) or stops itself (one-shot). Each channel drives its own level interrupt, which is gated by a per-channel enable.

Software reaches the timer through a plain 16-bit read/write port: one write strobe and a byte address. Reads are combinational from the address. Every channel exposes four words: control, event status, limit and live count. A typical use has one channel in periodic mode producing a system tick and the other running free over the full 16-bit range as a time base. Reset is synchronous and active low.

Top module: `dual_timer`

## Requirements
- R1: Channel c (c = 0 or 1) has its control word at byte address 0x80 + c*0x80, status at +0x04, limit at +0x08 and live count at +0x0C. Any other address (including 0x000, 0x090, 0x180 and any address with bits [1:0] not zero) reads as 0, and writes to it change no register.
- R2: In the control word, bit 8 is interrupt enable, bit 5 is run, bit 4 selects one-shot (1) or periodic (0), and bits [3:0] are the prescaler code. All other bits read as 0, so a control read returns the written value ANDed with 0x013F.
- R3: With prescaler code p, the count advances once every 2^min(p,8) clocks. Codes 9 to 15 behave as code 8.
- R4: A control write that takes run from 0 to 1 clears the count and the prescaler divider. The first event then arrives exactly limit*2^min(p,8) clocks after that write edge. This holds for limits from 3 up to 0xFFF0.
- R5: The live count reads the number of prescaled ticks since the start, counting upward. Writes to the count address are ignored.
- R6: When an advance would bring the count to the limit, the channel sets status bit 0 and loads the count with 0. In periodic mode it keeps running, so the next event follows limit*2^min(p,8) clocks later.
- R7: In one-shot mode, the event also clears the run bit, and the count then stays at 0.
- R8: Writing a 1 to status bit 0 clears it. Writing a 0 leaves it unchanged. If an event and a clearing write fall on the same edge, the status ends up set.
- R9: A channel's interrupt output equals its status bit ANDed with its interrupt-enable bit. It stays high until the status is cleared or the enable is dropped.
- R10: Clearing the run bit stops the channel, and the count holds its value. The limit may be rewritten at any time.
- R11: The two channels are independent. Activity on one never sets the status or the interrupt of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 2 | Per-channel interrupt level |

## Verification
The bench builds the block with its default parameters: two channels, a 9-bit address, a base of 0x80 and a stride of 0x80. With this setup, both channels and the address holes around and beyond them can be reached. Because the limit is the full 16 bits wide, the 0xFFF0 limit case fits in the run. Since the prescaler field is four bits, codes 9 to 15 can also be driven, which exercises the clamp to divide-by-256.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int DATA_W  = 16;
    localparam int PSC_W   = 4;
    localparam int MAX_PSC = 8;
    localparam int DIV_W   = MAX_PSC;

    localparam int CTRL_IEN_BIT = 8;
    localparam int CTRL_RUN_BIT = 5;
    localparam int CTRL_OS_BIT  = 4;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_LIMIT = 2'd2,
        SEL_COUNT = 2'd3
    } reg_sel_t;

    typedef struct packed {
        logic             ien;
        logic             run;
        logic             oneshot;
        logic [PSC_W-1:0] psc;
    } ctrl_t;

    function automatic reg_sel_t sel_of(input int r);
        case (r)
            0:       return SEL_CTRL;
            1:       return SEL_STAT;
            2:       return SEL_LIMIT;
            default: return SEL_COUNT;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w               = '0;
        w[CTRL_IEN_BIT] = c.ien;
        w[CTRL_RUN_BIT] = c.run;
        w[CTRL_OS_BIT]  = c.oneshot;
        w[PSC_W-1:0]    = c.psc;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.ien     = w[CTRL_IEN_BIT];
        c.run     = w[CTRL_RUN_BIT];
        c.oneshot = w[CTRL_OS_BIT];
        c.psc     = w[PSC_W-1:0];
        return c;
    endfunction

    // Terminal value of the divider for a prescaler code, clamped to MAX_PSC.
    function automatic logic [DIV_W-1:0] div_mask(input logic [PSC_W-1:0] p);
        logic [DIV_W-1:0] m;
        int               e;
        e = (int'(p) > MAX_PSC) ? MAX_PSC : int'(p);
        for (int i = 0; i < DIV_W; i++) begin
            m[i] = (i < e);
        end
        return m;
    endfunction

endpackage

// File: rtl/timer_regdec.sv
module timer_regdec
    import timer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 9,
    parameter int BASE   = 'h80,
    parameter int STRIDE = 'h80,
    parameter int CH_W   = 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [CH_W-1:0]   ch_o,
    output reg_sel_t          sel_o
);

    localparam int REGS_PER_CH = 4;
    localparam int WORD_BYTES  = 4;

    always_comb begin
        hit_o = 1'b0;
        ch_o  = '0;
        sel_o = SEL_CTRL;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int r = 0; r < REGS_PER_CH; r++) begin
                if (addr_i == ADDR_W'(BASE + c * STRIDE + r * WORD_BYTES)) begin
                    hit_o = 1'b1;
                    ch_o  = CH_W'(c);
                    sel_o = sel_of(r);
                end
            end
        end
    end

endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler
    import timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] term;

    assign term   = div_mask(psc_i);
    assign tick_o = run_i && (div_q == term);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr_i || !run_i || tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic              wr_stat_i,
    input  logic              wr_limit_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctrl_word_o,
    output logic              stat_o,
    output logic [DATA_W-1:0] limit_o,
    output logic [DATA_W-1:0] count_o,
    output logic              run_o,
    output logic              ien_o,
    output logic              oneshot_o,
    output logic              irq_o
);

    ctrl_t             ctrl_q;
    ctrl_t             ctrl_wr;
    logic [DATA_W-1:0] limit_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cnt_nxt;
    logic              stat_q;
    logic              start;
    logic              tick;
    logic              match;

    assign ctrl_wr = word_to_ctrl(wdata_i);
    assign start   = wr_ctrl_i && ctrl_wr.run && !ctrl_q.run;
    assign cnt_nxt = cnt_q + 1'b1;
    assign match   = tick && (cnt_nxt == limit_q);

    timer_prescaler u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start),
        .run_i  (ctrl_q.run),
        .psc_i  (ctrl_q.psc),
        .tick_o (tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl_i) begin
            ctrl_q <= ctrl_wr;
        end else if (match && ctrl_q.oneshot) begin
            ctrl_q.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (wr_limit_i) begin
            limit_q <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= match ? '0 : cnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (match) begin
            stat_q <= 1'b1;
        end else if (wr_stat_i && wdata_i[0]) begin
            stat_q <= 1'b0;
        end
    end

    assign ctrl_word_o = ctrl_to_word(ctrl_q);
    assign stat_o      = stat_q;
    assign limit_o     = limit_q;
    assign count_o     = cnt_q;
    assign run_o       = ctrl_q.run;
    assign ien_o       = ctrl_q.ien;
    assign oneshot_o   = ctrl_q.oneshot;
    assign irq_o       = stat_q & ctrl_q.ien;

endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import timer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 9,
    parameter int BASE   = 'h80,
    parameter int STRIDE = 'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic                     hit;
    logic [CH_W-1:0]          ch_sel;
    reg_sel_t                 reg_sel;

    logic [DATA_W-1:0]        ctrl_word [NUM_CH];
    logic [DATA_W-1:0]        limit_w   [NUM_CH];
    logic [DATA_W-1:0]        count_w   [NUM_CH];
    logic [NUM_CH-1:0]        stat_v;
    logic [NUM_CH-1:0]        run_v;
    logic [NUM_CH-1:0]        ien_v;
    logic [NUM_CH-1:0]        os_v;
    logic [NUM_CH*DATA_W-1:0] cnt_v;

    timer_regdec #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .BASE   (BASE),
        .STRIDE (STRIDE),
        .CH_W   (CH_W)
    ) u_dec (
        .addr_i (bus_addr),
        .hit_o  (hit),
        .ch_o   (ch_sel),
        .sel_o  (reg_sel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic mine;
        assign mine = bus_wr && hit && (ch_sel == CH_W'(c));

        timer_channel u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_ctrl_i   (mine && (reg_sel == SEL_CTRL)),
            .wr_stat_i   (mine && (reg_sel == SEL_STAT)),
            .wr_limit_i  (mine && (reg_sel == SEL_LIMIT)),
            .wdata_i     (bus_wdata),
            .ctrl_word_o (ctrl_word[c]),
            .stat_o      (stat_v[c]),
            .limit_o     (limit_w[c]),
            .count_o     (count_w[c]),
            .run_o       (run_v[c]),
            .ien_o       (ien_v[c]),
            .oneshot_o   (os_v[c]),
            .irq_o       (irq[c])
        );

        assign cnt_v[c*DATA_W +: DATA_W] = count_w[c];
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            case (reg_sel)
                SEL_CTRL:  bus_rdata = ctrl_word[ch_sel];
                SEL_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, stat_v[ch_sel]};
                SEL_LIMIT: bus_rdata = limit_w[ch_sel];
                default:   bus_rdata = count_w[ch_sel];
            endcase
        end
    end

endmodule

// File: rtl/timer_chk.sv
module timer_chk
    import timer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 9
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_wr,
    input logic [DATA_W-1:0]        bus_rdata,
    input logic [NUM_CH-1:0]        irq,
    input logic [NUM_CH-1:0]        stat_v,
    input logic [NUM_CH-1:0]        run_v,
    input logic [NUM_CH-1:0]        ien_v,
    input logic [NUM_CH-1:0]        os_v,
    input logic [NUM_CH*DATA_W-1:0] cnt_v
);

    AST_UNALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0)); // R1

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            !ien_v[c] |-> !irq[c]); // R9

        AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[c]) |-> $past(bus_wr)); // R9

        AST_MATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_v[c]) |-> (cnt_v[c*DATA_W +: DATA_W] == '0)); // R6

        AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(stat_v[c]) && os_v[c] && !$past(bus_wr)) |-> !run_v[c]); // R7

        AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_v[c] && $past(!run_v[c])) |-> $stable(cnt_v[c*DATA_W +: DATA_W])); // R10
    end

endmodule

bind dual_timer timer_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .stat_v    (stat_v),
    .run_v     (run_v),
    .ien_v     (ien_v),
    .os_v      (os_v),
    .cnt_v     (cnt_v)
);

// File: tb/dual_timer_tb.sv
`timescale 1ns/1ps
module dual_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int vectors = 0;
    int miss = 0;
    int cyc = 0;
    bit done = 1'b0;

    dual_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            miss++;
            $display("FAIL watchdog: got timeout exp finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    end

    function automatic int radr(input int ch, input int r);
        return 'h80 + ch * 'h80 + r * 4;
    endfunction

    function automatic int exp_clocks(input int lim, input int p);
        int e;
        e = (p > 8) ? 8 : p;
        return ((lim == 0) ? 65536 : lim) << e;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miss++;
            $display("FAIL %s: got 0x%0h exp 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr  = 9'(a);
        bus_wdata = 16'(d);
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        bus_addr = 9'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic start_ch(input int ch, input int lim, input int p,
                            input int os, input int ien);
        wr(radr(ch, 0), 0);
        wr(radr(ch, 1), 1);
        wr(radr(ch, 2), lim);
        wr(radr(ch, 0), (ien << 8) | (1 << 5) | (os << 4) | p);
    endtask

    task automatic wait_stat(input int ch, input int limit, output int n);
        bus_addr = 9'(radr(ch, 1));
        n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
        end while (!bus_rdata[0] && n < limit);
    endtask

    initial begin
        int d, n, lim, p, ch;
        void'($urandom(32'd20240611));

        idle(4);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // Reset state
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 4; r++) begin
                rd(radr(c, r), d);
                check("R1 reset register", d, 0);
            end
        end
        check("R9 reset irq", int'(irq), 0);

        // Control field readback
        wr(radr(0, 0), 'hFEDF);
        rd(radr(0, 0), d);
        check("R2 control mask", d, 'hFEDF & 'h013F);
        wr(radr(0, 0), 0);

        // First interval, small limit, periodic, interrupt enabled
        start_ch(0, 3, 0, 0, 1);
        wait_stat(0, 1000, n);
        check("R4 limit 3 first event", n, exp_clocks(3, 0));
        check("R9 irq high on event", int'(irq), 1);
        check("R11 other channel quiet", int'(irq[1]), 0);
        idle(5);
        check("R9 irq held", int'(irq[0]), 1);
        wr(radr(0, 1), 0);
        rd(radr(0, 1), d);
        check("R8 write zero keeps status", d, 1);

        // Periodic second interval
        start_ch(0, 40, 2, 0, 1);
        wait_stat(0, 10000, n);
        check("R4 limit 40 p2 first", n, exp_clocks(40, 2));
        wr(radr(0, 1), 1);
        check("R8 clear drops irq", int'(irq[0]), 0);
        wait_stat(0, 10000, n);
        check("R6 periodic next event", n, exp_clocks(40, 2) - 1);

        // Clear on the same edge as a match: set wins
        wr(radr(0, 1), 1);
        idle(exp_clocks(40, 2) - 2);
        wr(radr(0, 1), 1);
        rd(radr(0, 1), d);
        check("R8 match beats clear", d, 1);

        // Mid-interval count
        start_ch(1, 100, 2, 0, 0);
        idle(37);
        rd(radr(1, 3), d);
        check("R5 live count", d, 37 >> 2);

        // Stop holds count; count write ignored; restart clears
        start_ch(1, 1000, 0, 0, 0);
        idle(50);
        wr(radr(1, 0), 0);
        idle(10);
        rd(radr(1, 3), d);
        check("R10 stopped count held", d, 51);
        wr(radr(1, 3), 'h1234);
        rd(radr(1, 3), d);
        check("R5 count write ignored", d, 51);
        wr(radr(1, 2), 7);
        rd(radr(1, 2), d);
        check("R10 limit rewritten", d, 7);
        wr(radr(1, 0), 1 << 5);
        rd(radr(1, 3), d);
        check("R4 restart clears count", d, 0);
        wait_stat(1, 1000, n);
        check("R4 restarted interval", n, 7);

        // Interrupt masked
        check("R9 masked irq", int'(irq[1]), 0);
        check("R11 ch0 status untouched by ch1", int'(irq[0]), 1);

        // One-shot
        start_ch(0, 9, 1, 1, 1);
        wait_stat(0, 1000, n);
        check("R7 oneshot event time", n, exp_clocks(9, 1));
        rd(radr(0, 0), d);
        check("R7 run cleared", (d >> 5) & 1, 0);
        idle(30);
        rd(radr(0, 3), d);
        check("R7 count parked at zero", d, 0);
        rd(radr(0, 1), d);
        check("R7 single event status", d, 1);

        // Prescaler clamp
        start_ch(1, 3, 12, 0, 0);
        wait_stat(1, 5000, n);
        check("R3 code 12 clamps to 256", n, exp_clocks(3, 12));

        // Unmapped addresses
        wr(radr(0, 0), 0);
        wr(radr(1, 0), 0);
        wr(radr(0, 2), 'h0055);
        wr('h000, 'hFFFF);
        wr('h090, 'hFFFF);
        wr('h180, 'hFFFF);
        wr('h082, 'hFFFF);
        rd(radr(0, 2), d);
        check("R1 hole write ignored limit", d, 'h55);
        rd(radr(0, 0), d);
        check("R1 hole write ignored ctrl", d, 0);
        rd('h000, d);
        check("R1 hole read 0x000", d, 0);
        rd('h090, d);
        check("R1 hole read 0x090", d, 0);
        rd('h180, d);
        check("R1 hole read 0x180", d, 0);
        rd('h089, d);
        check("R1 unaligned read", d, 0);

        // Random intervals
        for (int i = 0; i < 6; i++) begin
            ch  = int'($urandom % 2);
            lim = 3 + int'($urandom % 60);
            p   = int'($urandom % 7);
            start_ch(ch, lim, p, int'($urandom % 2), 1);
            wait_stat(ch, 20000, n);
            check("R3 random interval", n, exp_clocks(lim, p));
            check("R11 random other irq", int'(irq[1-ch]), 0);
            wr(radr(ch, 0), 0);
            wr(radr(ch, 1), 1);
        end

        // Largest tested limit
        start_ch(1, 'hFFF0, 0, 0, 1);
        wait_stat(1, 70000, n);
        check("R4 limit 0xFFF0", n, exp_clocks('hFFF0, 0));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

endmodule